// File: doc/BRIEF.md
# Scheduler Debug Counter Bank

This block is a read-only AXI4-Lite slave that lets software watch the internal state of a task scheduler serving up to 64 accelerators. It counts copy optimizations on the scheduler's input and output command queues. It mirrors two live per-accelerator status vectors: availability and queue-not-empty. For every accelerator it counts the commands received, the commands issued and the clock cycles spent busy.

The scheduler drives one-cycle event pulses and level status vectors into the block. Software reads 32-bit words from a 16 KB window addressed by 14-bit byte addresses. Registers wider than 32 bits are split across two consecutive words, with the low word at the lower address. Nothing in the block can be written or cleared except by reset. Counter widths and the accelerator count are parameters, so a narrow build can be used to watch the counters roll over.

Top module: `dbgc_counter_bank`

## Requirements
- R1: A write transaction (AW and W presented together) is accepted and answered with BRESP = 2'b10 (error), and afterwards every readable register holds the value it would have had without the write.
- R2: The word at byte offset 0x000 counts cycles with `copy_in_pulse` high, and the word at offset 0x004 counts cycles with `copy_out_pulse` high.
- R3: Offsets 0x008 (low word) and 0x00C (high word) return the availability bitmap, with bit i belonging to accelerator i; bits at or above NUM_ACC read as zero.
- R4: Offsets 0x010 (low word) and 0x014 (high word) return the queue-not-empty bitmap, with the same bit layout as R3.
- R5: The word at 0x800 + 4*i counts the cycles in which `cmd_rx_pulse[i]` is high.
- R6: The word at 0x900 + 4*i counts the cycles in which `cmd_tx_pulse[i]` is high.
- R7: The busy-cycle counter of accelerator i increments on every cycle in which `acc_avail[i]` is low; its low word reads at 0xA00 + 8*i and its high word at 0xA04 + 8*i.
- R8: A read of an offset that maps to no register, or of a per-accelerator slot whose index is NUM_ACC or more, returns zero with RRESP = 2'b00.
- R9: Event counters are EVT_W bits wide and busy counters BUSY_W bits wide; each wraps to zero on overflow, and the read value is zero-extended.
- R10: One read is outstanding at a time: while RVALID is high, ARREADY is low and RDATA stays fixed until RREADY is seen, even if counters change meanwhile.
- R11: After reset all counters read zero and RVALID and BVALID are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 14 | Write address (ignored) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data (ignored) |
| s_wstrb | input | 4 | Write strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always error |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 14 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| copy_in_pulse | input | 1 | Copy optimization seen on the input queue |
| copy_out_pulse | input | 1 | Copy optimization seen on the output queue |
| acc_avail | input | NUM_ACC | Per-accelerator availability, low = busy |
| queue_nempty | input | NUM_ACC | Per-accelerator queue-not-empty flags |
| cmd_rx_pulse | input | NUM_ACC | Per-accelerator command-received pulses |
| cmd_tx_pulse | input | NUM_ACC | Per-accelerator command-issued pulses |

## Verification
A counter that misses or doubles an event shows up in the very next read of its word as a value that differs from the number of pulses driven. A decode that points at the wrong slot shows a neighbour's count, or a nonzero value where an unpopulated slot must read zero. A busy counter with the wrong enable drifts by one per cycle, so a fixed busy window of known length exposes it at once. Corrupted read-channel state shows within a cycle as RDATA moving while the response is held, or as a second address being accepted during it.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    localparam int ADDR_W    = 14;
    localparam int WADDR_W   = ADDR_W - 2;
    localparam int DATA_W    = 32;
    localparam int ACC_SLOTS = 64;
    localparam int IDX_W     = $clog2(ACC_SLOTS);

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    // Word-address fields of the per-accelerator arrays
    localparam logic [5:0] RX_PAGE   = 6'h08;   // 0x800 >> 2 >> 6
    localparam logic [5:0] TX_PAGE   = 6'h09;   // 0x900 >> 2 >> 6
    localparam logic [4:0] BUSY_PAGE = 5'h05;   // 0xA00 >> 2 >> 7

    typedef enum logic [2:0] {
        RG_NONE,
        RG_COPY_IN,
        RG_COPY_OUT,
        RG_AVAIL,
        RG_NEMPTY,
        RG_RX,
        RG_TX,
        RG_BUSY
    } region_e;

    typedef struct packed {
        region_e          region;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } rd_sel_t;

    // Map a word address onto a register region, slot and half.
    function automatic rd_sel_t decode_word(input logic [WADDR_W-1:0] w);
        rd_sel_t s;
        s.region = RG_NONE;
        s.idx    = '0;
        s.hi     = 1'b0;
        if (w[WADDR_W-1:3] == '0) begin
            case (w[2:0])
                3'd0: s.region = RG_COPY_IN;
                3'd1: s.region = RG_COPY_OUT;
                3'd2: s.region = RG_AVAIL;
                3'd3: begin s.region = RG_AVAIL;  s.hi = 1'b1; end
                3'd4: s.region = RG_NEMPTY;
                3'd5: begin s.region = RG_NEMPTY; s.hi = 1'b1; end
                default: s.region = RG_NONE;
            endcase
        end else if (w[11:6] == RX_PAGE) begin
            s.region = RG_RX;
            s.idx    = w[5:0];
        end else if (w[11:6] == TX_PAGE) begin
            s.region = RG_TX;
            s.idx    = w[5:0];
        end else if (w[11:7] == BUSY_PAGE) begin
            s.region = RG_BUSY;
            s.idx    = w[6:1];
            s.hi     = w[0];
        end
        return s;
    endfunction

endpackage

// File: rtl/dbgc_event_ctr.sv
module dbgc_event_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (inc) value <= value + W'(1);
    end

    // Counting rules
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(value));

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (inc && !(&value)) |=> (value == $past(value) + W'(1)));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (inc && (&value)) |=> (value == '0));

endmodule

// File: rtl/dbgc_ctr_bank.sv
module dbgc_ctr_bank
    import dbgc_pkg::*;
#(
    parameter int NUM_ACC = 64,
    parameter int EVT_W   = 32,
    parameter int BUSY_W  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               copy_in_pulse,
    input  logic               copy_out_pulse,
    input  logic [NUM_ACC-1:0] acc_avail,
    input  logic [NUM_ACC-1:0] queue_nempty,
    input  logic [NUM_ACC-1:0] cmd_rx_pulse,
    input  logic [NUM_ACC-1:0] cmd_tx_pulse,
    output logic [DATA_W-1:0]  copy_in_cnt,
    output logic [DATA_W-1:0]  copy_out_cnt,
    output logic [63:0]        avail_map,
    output logic [63:0]        nempty_map,
    output logic [DATA_W-1:0]  rx_cnt   [ACC_SLOTS],
    output logic [DATA_W-1:0]  tx_cnt   [ACC_SLOTS],
    output logic [63:0]        busy_cnt [ACC_SLOTS]
);

    logic [EVT_W-1:0] cin_q, cout_q;

    dbgc_event_ctr #(.W(EVT_W)) u_copy_in (
        .clk(clk), .rst(rst), .inc(copy_in_pulse), .value(cin_q));

    dbgc_event_ctr #(.W(EVT_W)) u_copy_out (
        .clk(clk), .rst(rst), .inc(copy_out_pulse), .value(cout_q));

    assign copy_in_cnt  = DATA_W'(cin_q);
    assign copy_out_cnt = DATA_W'(cout_q);
    assign avail_map    = 64'(acc_avail);
    assign nempty_map   = 64'(queue_nempty);

    for (genvar g = 0; g < ACC_SLOTS; g++) begin : g_slot
        if (g < NUM_ACC) begin : g_live
            logic [EVT_W-1:0]  rx_q, tx_q;
            logic [BUSY_W-1:0] busy_q;

            dbgc_event_ctr #(.W(EVT_W)) u_rx (
                .clk(clk), .rst(rst), .inc(cmd_rx_pulse[g]), .value(rx_q));

            dbgc_event_ctr #(.W(EVT_W)) u_tx (
                .clk(clk), .rst(rst), .inc(cmd_tx_pulse[g]), .value(tx_q));

            dbgc_event_ctr #(.W(BUSY_W)) u_busy (
                .clk(clk), .rst(rst), .inc(!acc_avail[g]), .value(busy_q));

            assign rx_cnt[g]   = DATA_W'(rx_q);
            assign tx_cnt[g]   = DATA_W'(tx_q);
            assign busy_cnt[g] = 64'(busy_q);
        end else begin : g_empty
            assign rx_cnt[g]   = '0;
            assign tx_cnt[g]   = '0;
            assign busy_cnt[g] = '0;
        end
    end

endmodule

// File: rtl/dbgc_read_mux.sv
module dbgc_read_mux
    import dbgc_pkg::*;
(
    input  rd_sel_t           sel,
    input  logic [DATA_W-1:0] copy_in_cnt,
    input  logic [DATA_W-1:0] copy_out_cnt,
    input  logic [63:0]       avail_map,
    input  logic [63:0]       nempty_map,
    input  logic [DATA_W-1:0] rx_cnt   [ACC_SLOTS],
    input  logic [DATA_W-1:0] tx_cnt   [ACC_SLOTS],
    input  logic [63:0]       busy_cnt [ACC_SLOTS],
    output logic [DATA_W-1:0] rd_word
);

    logic [63:0] busy_sel;

    assign busy_sel = busy_cnt[sel.idx];

    always_comb begin
        case (sel.region)
            RG_COPY_IN:  rd_word = copy_in_cnt;
            RG_COPY_OUT: rd_word = copy_out_cnt;
            RG_AVAIL:    rd_word = sel.hi ? avail_map[63:32]  : avail_map[31:0];
            RG_NEMPTY:   rd_word = sel.hi ? nempty_map[63:32] : nempty_map[31:0];
            RG_RX:       rd_word = rx_cnt[sel.idx];
            RG_TX:       rd_word = tx_cnt[sel.idx];
            RG_BUSY:     rd_word = sel.hi ? busy_sel[63:32] : busy_sel[31:0];
            default:     rd_word = '0;
        endcase
    end

endmodule

// File: rtl/dbgc_axil_port.sv
module dbgc_axil_port
    import dbgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              awvalid,
    output logic              awready,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [DATA_W-1:0] rd_word
);

    logic wr_fire, rd_fire;

    // Write side: both channels taken together, always refused
    assign wr_fire = awvalid && wvalid && !bvalid;
    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign bresp   = RESP_SLVERR;

    always_ff @(posedge clk) begin
        if (rst)               bvalid <= 1'b0;
        else if (wr_fire)      bvalid <= 1'b1;
        else if (bready)       bvalid <= 1'b0;
    end

    // Read side: one outstanding beat, data captured at acceptance
    assign arready = !rvalid;
    assign rd_fire = arvalid && arready;
    assign rresp   = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    assert_wr_resp_R1: assert property (@(posedge clk) disable iff (rst)
        (awvalid && wvalid && awready) |=> bvalid);

    assert_bresp_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid);

endmodule

// File: rtl/dbgc_counter_bank.sv
module dbgc_counter_bank
    import dbgc_pkg::*;
#(
    parameter int NUM_ACC = 64,
    parameter int EVT_W   = 32,
    parameter int BUSY_W  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [13:0]        s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [31:0]        s_wdata,
    input  logic [3:0]         s_wstrb,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [13:0]        s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [31:0]        s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    input  logic               copy_in_pulse,
    input  logic               copy_out_pulse,
    input  logic [NUM_ACC-1:0] acc_avail,
    input  logic [NUM_ACC-1:0] queue_nempty,
    input  logic [NUM_ACC-1:0] cmd_rx_pulse,
    input  logic [NUM_ACC-1:0] cmd_tx_pulse
);

    logic [DATA_W-1:0] copy_in_cnt, copy_out_cnt, rd_word;
    logic [63:0]       avail_map, nempty_map;
    logic [DATA_W-1:0] rx_cnt   [ACC_SLOTS];
    logic [DATA_W-1:0] tx_cnt   [ACC_SLOTS];
    logic [63:0]       busy_cnt [ACC_SLOTS];
    rd_sel_t           rd_sel;
    logic              unused_inputs;

    assign unused_inputs = ^{s_awaddr, s_wdata, s_wstrb, s_araddr[1:0]};
    assign rd_sel        = decode_word(s_araddr[ADDR_W-1:2]);

    dbgc_ctr_bank #(.NUM_ACC(NUM_ACC), .EVT_W(EVT_W), .BUSY_W(BUSY_W)) u_bank (
        .clk(clk), .rst(rst),
        .copy_in_pulse(copy_in_pulse), .copy_out_pulse(copy_out_pulse),
        .acc_avail(acc_avail), .queue_nempty(queue_nempty),
        .cmd_rx_pulse(cmd_rx_pulse), .cmd_tx_pulse(cmd_tx_pulse),
        .copy_in_cnt(copy_in_cnt), .copy_out_cnt(copy_out_cnt),
        .avail_map(avail_map), .nempty_map(nempty_map),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .busy_cnt(busy_cnt));

    dbgc_read_mux u_mux (
        .sel(rd_sel),
        .copy_in_cnt(copy_in_cnt), .copy_out_cnt(copy_out_cnt),
        .avail_map(avail_map), .nempty_map(nempty_map),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .busy_cnt(busy_cnt),
        .rd_word(rd_word));

    dbgc_axil_port u_port (
        .clk(clk), .rst(rst),
        .awvalid(s_awvalid), .awready(s_awready),
        .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .rd_word(rd_word));

    // Unpopulated slots are never selected with a nonzero value
    assert_empty_slot_R8: assert property (@(posedge clk) disable iff (rst)
        (s_arvalid && s_arready && (rd_sel.region inside {RG_RX, RG_TX, RG_BUSY})
         && (32'(rd_sel.idx) >= NUM_ACC)) |=> (s_rdata == '0));

endmodule

// File: tb/tb_dbgc_counter_bank.sv
module tb_dbgc_counter_bank;

    localparam int NA = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [13:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic copy_in = 0, copy_out = 0;
    logic [NA-1:0] avail = '1, nempty = '0, rx = '0, tx = '0;

    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic w_awready, w_wready, w_bvalid, w_arready, w_rvalid;
    logic [1:0] w_bresp, w_rresp;
    logic [31:0] w_rdata;

    int nchk = 0, nerr = 0;

    always #4 clk = ~clk;

    dbgc_counter_bank #(.NUM_ACC(NA)) dut (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .copy_in_pulse(copy_in), .copy_out_pulse(copy_out),
        .acc_avail(avail), .queue_nempty(nempty),
        .cmd_rx_pulse(rx), .cmd_tx_pulse(tx));

    // Narrow build sharing all stimulus, used to observe roll-over
    dbgc_counter_bank #(.NUM_ACC(NA), .EVT_W(4), .BUSY_W(6)) dut_w (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(w_awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(w_wready),
        .s_bresp(w_bresp), .s_bvalid(w_bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(w_arready),
        .s_rdata(w_rdata), .s_rresp(w_rresp), .s_rvalid(w_rvalid), .s_rready(rready),
        .copy_in_pulse(copy_in), .copy_out_pulse(copy_out),
        .acc_avail(avail), .queue_nempty(nempty),
        .cmd_rx_pulse(rx), .cmd_tx_pulse(tx));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d,
                      output logic [31:0] dw, output logic [1:0] r);
        @(negedge clk);
        araddr  = a;
        arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        d  = rvalid ? rdata : 32'hBAD0_BAD0;
        dw = w_rvalid ? w_rdata : 32'hBAD0_BAD0;
        r  = rresp;
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic pulse(input int kind, input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            case (kind)
                0: copy_in  = 1'b1;
                1: copy_out = 1'b1;
                2: rx[idx]  = 1'b1;
                default: tx[idx] = 1'b1;
            endcase
            @(negedge clk);
            copy_in = 1'b0; copy_out = 1'b0; rx = '0; tx = '0;
        end
    endtask

    task automatic busy_window(input int idx, input int n);
        @(negedge clk);
        avail[idx] = 1'b0;
        repeat (n) @(negedge clk);
        avail[idx] = 1'b1;
    endtask

    task automatic t_reset;
        logic [31:0] d, dw; logic [1:0] r;
        chk("R11 rvalid", rvalid, 0);
        chk("R11 bvalid", bvalid, 0);
        chk("R11 arready", arready, 1);
        rd(14'h000, d, dw, r); chk("R11 copy_in zero", d, 0);
        rd(14'hA00, d, dw, r); chk("R11 busy zero", d, 0);
    endtask

    task automatic t_copy;
        logic [31:0] d, dw; logic [1:0] r;
        pulse(0, 0, 3);
        pulse(1, 0, 5);
        rd(14'h000, d, dw, r); chk("R2 copy_in", d, 3);
        rd(14'h004, d, dw, r); chk("R2 copy_out", d, 5);
    endtask

    task automatic t_cmds;
        logic [31:0] d, dw; logic [1:0] r;
        pulse(2, 3, 4);
        pulse(2, 0, 1);
        pulse(3, 5, 2);
        rd(14'h80C, d, dw, r); chk("R5 rx acc3", d, 4);
        rd(14'h800, d, dw, r); chk("R5 rx acc0", d, 1);
        rd(14'h914, d, dw, r); chk("R6 tx acc5", d, 2);
        rd(14'h90C, d, dw, r); chk("R6 tx acc3 untouched", d, 0);
    endtask

    task automatic t_busy;
        logic [31:0] d, dw; logic [1:0] r;
        busy_window(2, 9);
        rd(14'hA10, d, dw, r); chk("R7 busy acc2 low", d, 9);
        rd(14'hA14, d, dw, r); chk("R7 busy acc2 high", d, 0);
        rd(14'hA18, d, dw, r); chk("R7 busy acc3 idle", d, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] d, dw; logic [1:0] r;
        pulse(2, 1, 17);
        rd(14'h804, d, dw, r);
        chk("R9 rx acc1 wide", d, 17);
        chk("R9 rx acc1 narrow wraps", dw, 1);
        busy_window(4, 70);
        rd(14'hA20, d, dw, r);
        chk("R9 busy acc4 wide", d, 70);
        chk("R9 busy acc4 narrow wraps", dw, 6);
        rd(14'hA24, d, dw, r); chk("R9 busy narrow high", dw, 0);
    endtask

    task automatic t_maps;
        logic [31:0] d, dw; logic [1:0] r;
        @(negedge clk);
        avail  = 6'b101101;
        nempty = 6'b010011;
        rd(14'h008, d, dw, r); chk("R3 avail low", d, 32'h2D);
        rd(14'h00C, d, dw, r); chk("R3 avail high", d, 0);
        rd(14'h010, d, dw, r); chk("R4 nempty low", d, 32'h13);
        rd(14'h014, d, dw, r); chk("R4 nempty high", d, 0);
        @(negedge clk);
        avail  = '1;
        nempty = '0;
    endtask

    task automatic t_unmapped;
        logic [31:0] d, dw; logic [1:0] r;
        pulse(2, 5, 1);
        rd(14'h818, d, dw, r); chk("R8 rx slot6", d, 0); chk("R8 resp", r, 0);
        rd(14'h918, d, dw, r); chk("R8 tx slot6", d, 0);
        rd(14'hA30, d, dw, r); chk("R8 busy slot6", d, 0);
        rd(14'h400, d, dw, r); chk("R8 hole 0x400", d, 0); chk("R8 resp hole", r, 0);
        rd(14'h018, d, dw, r); chk("R8 hole 0x018", d, 0);
        rd(14'h814, d, dw, r); chk("R8 slot5 live", d, 1);
    endtask

    task automatic t_hold;
        logic [31:0] d, dw, d0; logic [1:0] r;
        @(negedge clk);
        araddr = 14'h000; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        d0 = rdata;
        chk("R10 first value", d0, 3);
        copy_in = 1'b1;
        araddr  = 14'h004; arvalid = 1'b1;
        @(negedge clk);
        copy_in = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R10 rvalid held", rvalid, 1);
            chk("R10 arready low", arready, 0);
            chk("R10 rdata stable", rdata, d0);
            @(negedge clk);
        end
        arvalid = 1'b0;
        rready  = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        chk("R10 rvalid dropped", rvalid, 0);
        rd(14'h000, d, dw, r); chk("R10 pulse during hold counted", d, 4);
    endtask

    task automatic t_write;
        logic [31:0] d, dw; logic [1:0] r;
        @(negedge clk);
        awaddr = 14'h800; wdata = 32'hFFFF_FFFF; wstrb = 4'hF;
        awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        chk("R1 bvalid", bvalid, 1);
        chk("R1 bresp error", bresp, 2'b10);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        chk("R1 bvalid cleared", bvalid, 0);
        rd(14'h800, d, dw, r); chk("R1 rx acc0 unchanged", d, 1);
        rd(14'h000, d, dw, r); chk("R1 copy_in unchanged", d, 4);
    endtask

    initial begin
        #(8 * 100000);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_copy();
        t_cmds();
        t_busy();
        t_wrap();
        t_maps();
        t_unmapped();
        t_hold();
        t_write();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule